// File: doc/BRIEF.md
# Hybrid PWM/Analog Brightness Mapper

This block turns an 8-bit main-bank brightness register and an 8-bit auxiliary register into drive controls for the LED current sinks. The main bank has 32 perceived brightness steps. Each step is a mix of one of four analog current levels (20, 40, 70 or 100 percent of full scale) and a duty cycle of n/16. For every code the block outputs a 2-bit analog level select and a PWM gate. The auxiliary sink gets only a 2-bit analog level and has no PWM.

A prescaler divides the system clock into 16 slots per PWM frame, so the frame repeats at a fixed rate (20 kHz by default). Within a frame the gate is high for the first k slots, where k is the duty numerator. The main code is latched only at a frame boundary, so a write made partway through a frame never cuts a pulse short. Each bank has an enable input that forces its outputs off at once. Analog current generation is outside this block.

Top module: `bright_mapper`

## Requirements
- R1: Main codes 00h to 0Fh select level 0 (20 %, main_level_o = 2'b00) with a gate high for (code+1) of 16 slots.
- R2: Main codes 10h to 16h select level 1 (40 %, 2'b01) with duty rising from 10/16 to 16/16, which is (code-6)/16.
- R3: Main codes 17h to 1Ch select level 2 (70 %, 2'b10) with duty rising from 11/16 to 16/16, which is (code-12)/16.
- R4: Main codes 1Dh, 1Eh and 1Fh select level 3 (100 %, 2'b11) with duties of 13/16, 15/16 and 16/16.
- R5: A frame lasts 16 slots of CLK_HZ/(PWM_HZ*16) clocks each. Within a frame the gate is high for the first k slots and then low, so it never rises after a frame has started.
- R6: The main code is sampled only at a frame boundary. Changing the code during a frame leaves that frame's level and gate unchanged.
- R7: The auxiliary level equals aux_code_i[1:0] (00 = 20 %, 01 = 40 %, 10 = 70 %, 11 = 100 %). The auxiliary output has no PWM, and aux_on_o follows aux_en_i.
- R8: Only main_code_i[4:0] and aux_code_i[1:0] are decoded. The upper bits have no effect.
- R9: While a bank's enable input is 0, that bank's gate, on and level outputs are all 0, whatever its code.
- R10: From reset until the first frame boundary, main_on_o and main_gate_o are 0 and main_level_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_code_i | input | CODE_IN_W | Main-bank brightness register; bits 4:0 are used |
| aux_code_i | input | CODE_IN_W | Auxiliary brightness register; bits 1:0 are used |
| main_en_i | input | 1 | Main-bank enable |
| aux_en_i | input | 1 | Auxiliary enable |
| main_level_o | output | 2 | Main analog level select |
| main_gate_o | output | 1 | Main PWM gate |
| main_on_o | output | 1 | Main sink enable |
| aux_level_o | output | 2 | Auxiliary analog level select |
| aux_on_o | output | 1 | Auxiliary sink enable |

## Verification
Some properties hold on every cycle, and the assertions check these against a frame-phase counter of their own. The enable forcing and the reset-idle frame are checked this way. So are the stability of the main level inside a frame, the rule that the gate never rises after a frame has started, and the rule that an enabled frame always opens with the gate high. The exact duty numerator and level for each code range, the ignored upper bits, and the rule that a write during a frame is held back until the next frame can only be shown by the bench. It counts the high-gate cycles in each frame and compares them with values worked out from the code table.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int SLOTS  = 16;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DUTY_W = $clog2(SLOTS + 1);
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    LVL_20  = 2'b00,
    LVL_40  = 2'b01,
    LVL_70  = 2'b10,
    LVL_100 = 2'b11
  } lvl_e;
endpackage

// File: rtl/bm_prescale.sv
module bm_prescale #(
  parameter int DIV = 156
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bm_slot_ctr.sv
module bm_slot_ctr
  import bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wrap_o
);
  logic [SLOT_W-1:0] slot_q;

  assign slot_o = slot_q;
  assign wrap_o = tick_i && (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (tick_i) slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/bm_decode.sv
module bm_decode
  import bm_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output lvl_e              lvl_o,
  output logic [DUTY_W-1:0] duty_o
);
  // segment bases chosen so each step of code adds one sixteenth
  always_comb begin
    if (code_i < 5'd16) begin
      lvl_o  = LVL_20;
      duty_o = code_i + 5'd1;
    end else if (code_i < 5'd23) begin
      lvl_o  = LVL_40;
      duty_o = code_i - 5'd6;
    end else if (code_i < 5'd29) begin
      lvl_o  = LVL_70;
      duty_o = code_i - 5'd12;
    end else begin
      lvl_o = LVL_100;
      case (code_i)
        5'd29:   duty_o = 5'd13;
        5'd30:   duty_o = 5'd15;
        default: duty_o = 5'd16;
      endcase
    end
  end
endmodule

// File: rtl/bright_mapper.sv
module bright_mapper
  import bm_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PWM_HZ    = 20_000,
  parameter int CODE_IN_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CODE_IN_W-1:0] main_code_i,
  input  logic [CODE_IN_W-1:0] aux_code_i,
  input  logic                 main_en_i,
  input  logic                 aux_en_i,
  output logic [1:0]           main_level_o,
  output logic                 main_gate_o,
  output logic                 main_on_o,
  output logic [1:0]           aux_level_o,
  output logic                 aux_on_o
);
  localparam int SLOT_DIV  = (CLK_HZ / (PWM_HZ * SLOTS) > 0) ? CLK_HZ / (PWM_HZ * SLOTS) : 1;
  localparam int FRAME_CYC = SLOT_DIV * SLOTS;

  logic              tick, wrap;
  logic [SLOT_W-1:0] slot;
  lvl_e              dec_lvl, lvl_q;
  logic [DUTY_W-1:0] dec_duty, duty_q;
  logic              loaded_q;

  logic unused_hi_bits;
  assign unused_hi_bits = ^{main_code_i[CODE_IN_W-1:CODE_W], aux_code_i[CODE_IN_W-1:2]};

  bm_prescale #(.DIV(SLOT_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  bm_slot_ctr u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .slot_o (slot),
    .wrap_o (wrap)
  );

  bm_decode u_dec (
    .code_i (main_code_i[CODE_W-1:0]),
    .lvl_o  (dec_lvl),
    .duty_o (dec_duty)
  );

  // code takes effect only at frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= LVL_20;
      duty_q   <= '0;
      loaded_q <= 1'b0;
    end else if (wrap) begin
      lvl_q    <= dec_lvl;
      duty_q   <= dec_duty;
      loaded_q <= 1'b1;
    end
  end

  assign main_on_o    = main_en_i && loaded_q;
  assign main_gate_o  = main_on_o && ({1'b0, slot} < duty_q);
  assign main_level_o = main_on_o ? lvl_q : LVL_20;

  assign aux_on_o    = aux_en_i;
  assign aux_level_o = aux_en_i ? aux_code_i[1:0] : 2'b00;
endmodule

// File: rtl/bright_mapper_chk.sv
module bright_mapper_chk #(
  parameter int DIV   = 4,
  parameter int SLOTS = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       main_en_i,
  input logic       aux_en_i,
  input logic [1:0] main_level_o,
  input logic       main_gate_o,
  input logic       main_on_o,
  input logic [1:0] aux_level_o,
  input logic       aux_on_o
);
  localparam int FRAME = DIV * SLOTS;

  int   ph_q;
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= 0;
      first_q <= 1'b1;
    end else begin
      ph_q <= (ph_q == FRAME - 1) ? 0 : ph_q + 1;
      if (ph_q == FRAME - 1) first_q <= 1'b0;
    end
  end

  AST_MAIN_DIS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_en_i |-> (!main_gate_o && !main_on_o && main_level_o == 2'b00)); // R9

  AST_AUX_DIS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_en_i |-> (!aux_on_o && aux_level_o == 2'b00)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (!main_on_o && !main_gate_o && main_level_o == 2'b00)); // R10

  AST_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != 0 && main_en_i && $past(main_en_i)) |-> $stable(main_level_o)); // R6

  AST_NO_MID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != 0 && main_en_i && $past(main_en_i)) |-> !$rose(main_gate_o)); // R5

  AST_FRAME_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == 0 && main_on_o) |-> main_gate_o); // R5
endmodule

bind bright_mapper bright_mapper_chk #(.DIV(SLOT_DIV), .SLOTS(bm_pkg::SLOTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .main_en_i    (main_en_i),
  .aux_en_i     (aux_en_i),
  .main_level_o (main_level_o),
  .main_gate_o  (main_gate_o),
  .main_on_o    (main_on_o),
  .aux_level_o  (aux_level_o),
  .aux_on_o     (aux_on_o)
);

// File: tb/test_bright_mapper.sv
module test_bright_mapper;
  // CLK_HZ scaled so a slot is 4 clocks and a frame 64 clocks
  localparam int DIV    = 4;
  localparam int FRAME  = DIV * 16;
  localparam int CLK_HZ = 20_000 * 16 * DIV;

  typedef struct {
    int hi;
    int lvl;
    bit on;
    string req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] main_code = 8'h00, aux_code = 8'h00;
  logic       main_en = 1'b0, aux_en = 1'b0;
  logic [1:0] main_level, aux_level;
  logic       main_gate, main_on, aux_on;

  int checks = 0, fails = 0, cyc = 0;
  item_t q[$];

  always #10 clk = ~clk;

  bright_mapper #(.CLK_HZ(CLK_HZ), .PWM_HZ(20_000), .CODE_IN_W(8)) i_bright_mapper (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .main_code_i  (main_code),
    .aux_code_i   (aux_code),
    .main_en_i    (main_en),
    .aux_en_i     (aux_en),
    .main_level_o (main_level),
    .main_gate_o  (main_gate),
    .main_on_o    (main_on),
    .aux_level_o  (aux_level),
    .aux_on_o     (aux_on)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_map(input logic [7:0] code, output int duty, output int lvl, output string req);
    int c = int'(code[4:0]);
    if (c <= 15)      begin lvl = 0; duty = c + 1;  req = "R1"; end
    else if (c <= 22) begin lvl = 1; duty = c - 6;  req = "R2"; end
    else if (c <= 28) begin lvl = 2; duty = c - 12; req = "R3"; end
    else begin
      lvl = 3; req = "R4";
      duty = (c == 29) ? 13 : (c == 30) ? 15 : 16;
    end
  endfunction

  // drive at the last cycle of a frame so the next frame sees the new values
  task automatic apply(input logic [7:0] mc, input logic [7:0] ac, input bit men, input bit aen, input string tag);
    item_t it;
    int duty, lvl;
    string req;
    do @(negedge clk); while (cyc % FRAME != FRAME - 1);
    #2;
    main_code = mc; aux_code = ac; main_en = men; aux_en = aen;
    ref_map(mc, duty, lvl, req);
    it.hi  = men ? duty * DIV : 0;
    it.lvl = men ? lvl : 0;
    it.on  = men;
    it.req = {req, " ", tag};
    q.push_back(it);
    #1;
    check({"R7 aux level ", tag}, int'(aux_level), aen ? int'(ac[1:0]) : 0);
    check({"R7 aux on ", tag}, int'(aux_on), int'(aen));
  endtask

  task automatic glitch_code(input logic [7:0] mc);
    do @(negedge clk); while (cyc % FRAME != FRAME / 2);
    #2;
    main_code = mc;
  endtask

  // monitor: one expected item per frame
  initial begin : monitor
    item_t cur;
    int hi, lbad, obad, gbad;
    bit act;
    cur.hi = 0; cur.lvl = 0; cur.on = 0; cur.req = "R10 reset";
    act = 1'b1; hi = 0; lbad = 0; obad = 0; gbad = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (cyc % FRAME == 0) begin
        act = (q.size() > 0);
        if (act) cur = q.pop_front();
        hi = 0; lbad = 0; obad = 0; gbad = 0;
      end
      if (act) begin
        // gate must be a prefix of the frame (R5)
        if (main_gate && (cyc % FRAME) >= hi + (cyc % FRAME == 0 ? 0 : 0) && hi != (cyc % FRAME)) gbad++;
        if (main_gate) hi++;
        if (int'(main_level) != cur.lvl) lbad++;
        if (main_on != cur.on) obad++;
        if (cyc % FRAME == FRAME - 1) begin
          check({cur.req, " gate cycles"}, hi, cur.hi);
          check({cur.req, " level mismatching cycles"}, lbad, 0);
          check({cur.req, " on mismatching cycles"}, obad, 0);
          check({"R5 gate not a frame prefix ", cur.req}, gbad, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset gate", int'(main_gate), 0);
    check("R10 reset on", int'(main_on), 0);
    apply(8'h00, 8'h00, 1, 1, "code 00 aux 00");
    apply(8'h0F, 8'h01, 1, 1, "code 0F aux 01");
    apply(8'h07, 8'h02, 1, 1, "code 07 aux 10");
    apply(8'h10, 8'h03, 1, 1, "code 10 aux 11");
    apply(8'h16, 8'h01, 1, 0, "code 16 aux disabled");
    apply(8'h17, 8'h02, 1, 1, "code 17");
    apply(8'h1C, 8'h02, 1, 1, "code 1C");
    apply(8'h1D, 8'h03, 1, 1, "code 1D");
    apply(8'h1E, 8'h03, 1, 1, "code 1E");
    apply(8'h1F, 8'h03, 1, 1, "code 1F");
    apply(8'hE3, 8'hFD, 1, 1, "R8 upper bits set code E3 aux FD");
    apply(8'h02, 8'h00, 1, 1, "R6 frame before mid-frame write");
    glitch_code(8'h1F);
    apply(8'h05, 8'h00, 1, 1, "code 05 after mid-frame write");
    apply(8'h1F, 8'h03, 0, 0, "R9 main disabled code 1F");
    apply(8'h1A, 8'h00, 1, 1, "code 1A re-enabled");
    wait (q.size() == 0);
    do @(negedge clk); while (cyc % FRAME != FRAME - 1);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule